// File: doc/BRIEF.md
# Sobel Gradient Threshold Core

This block turns a stream of 8-bit grayscale pixels into binary edge decisions. A producer presents the nine pixels of a 3×3 neighbourhood one at a time in raster order (top row left to right, then the middle row, then the bottom row). Each pixel is qualified by a valid strobe. After the ninth accepted pixel the core emits one output pixel. That pixel is fully white when the window holds a strong intensity change and fully black when it does not.

The core estimates the horizontal and vertical intensity gradients with the 3×3 Sobel weights. The weights of two are left shifts, so there are no multipliers. The core adds the absolute values of the two gradients to get a magnitude, with no square root, and compares that magnitude with a threshold supplied on a port. The arithmetic is split into two registered stages, and each stage keeps its adder chain short. The first stage runs when the eighth pixel arrives and uses the pixels already gathered. The second stage adds the ninth pixel's contribution, takes the magnitude and applies the threshold. The decision is therefore ready in the cycle right after the ninth pixel, and the next window may begin loading in that same cycle. Everything runs on one clock with a synchronous reset.

Top module: `sobel_edge_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core clears its pixel count, `edge_vld` and `edge_pix` to zero at that edge. The first pixel accepted after reset is treated as the top-left pixel of a new window.
- R2: The horizontal gradient is (p3 + 2·p6 + p9) − (p1 + 2·p4 + p7). Here p1..p9 are the accepted pixels of a window in raster order: p1 to p3 are the top row, p4 to p6 the middle row, p7 to p9 the bottom row.
- R3: The vertical gradient is (p7 + 2·p8 + p9) − (p1 + 2·p2 + p3), using the same pixel numbering.
- R4: The magnitude is |horizontal| + |vertical|. `edge_pix` is 8'hFF when the magnitude is strictly greater than `thr` and 8'h00 otherwise, so a magnitude equal to `thr` gives 8'h00.
- R5: `edge_vld` is high for exactly one cycle: the cycle that follows the cycle in which the ninth pixel of a window is accepted. For nine back-to-back pixels, that is the tenth cycle.
- R6: A cycle with `pix_vld` low is ignored. It adds no pixel to the window, does not change which pixel comes next, and never raises `edge_vld`.
- R7: A new window may begin in the cycle right after its predecessor's ninth pixel. Back-to-back windows therefore give one result every nine cycles, each computed from its own nine pixels.
- R8: `edge_pix` keeps its value in every cycle in which `edge_vld` is low.
- R9: `thr` is sampled only at the clock edge that accepts the ninth pixel. Its value during the first eight pixels has no effect.
- R10: No intermediate result wraps. Windows at the extremes of the pixel range give their true magnitude (up to 1530 for 8-bit pixels), and `thr` = 4095 always gives 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_vld | input | 1 | Qualifies `pix` in this cycle |
| pix | input | PIX_W (8) | Grayscale pixel, raster order within the window |
| thr | input | PIX_W+4 (12) | Unsigned magnitude threshold |
| edge_vld | output | 1 | One-cycle strobe marking a new decision |
| edge_pix | output | PIX_W (8) | All ones for an edge, all zeros otherwise |

## Verification
The checker watches four things on every cycle. The result strobe must never last two cycles. A result may appear only right after an accepted pixel that completes a nine-pixel count. The output must hold between strobes, and every result must be all ones or all zeros. Only the bench's scenarios can show that the gradient weights, the magnitude and the strict comparison are right. To do so, the bench sets the threshold one below and exactly at the magnitude it computed for each window. The bench's scenarios also show that idle cycles leave the window intact, that a reset in the middle of a window restarts the count, and that only the threshold value present with the ninth pixel counts.

// File: rtl/sobel_pkg.sv
`timescale 1ns/1ps
package sobel_pkg;
   // Number of pixels in one neighbourhood and the number held before the last one arrives
   localparam int WIN_PIX  = 9;
   localparam int HIST_PIX = 7;
   typedef logic [3:0] win_cnt_t;
endpackage

// File: rtl/sobel_win_loader.sv
`timescale 1ns/1ps
module sobel_win_loader
   import sobel_pkg::*;
#(
   parameter int PIX_W = 8
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          pix_vld,
   input  logic [PIX_W-1:0]              pix,
   output logic [HIST_PIX-1:0][PIX_W-1:0] hist,
   output logic                          fire8,
   output logic                          fire9
);
   localparam win_cnt_t LAST_IDX = win_cnt_t'(WIN_PIX - 1);
   localparam win_cnt_t PEN_IDX  = win_cnt_t'(WIN_PIX - 2);

   win_cnt_t cnt;

   assign fire8 = pix_vld && (cnt == PEN_IDX);
   assign fire9 = pix_vld && (cnt == LAST_IDX);

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (pix_vld)
         cnt <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
   end

   // shift chain: the newest pixel enters at the top, so after seven pixels hist[k] is p(k+1)
   always_ff @(posedge clk) begin
      if (pix_vld)
         hist[HIST_PIX-1] <= pix;
   end

   for (genvar k = 0; k < HIST_PIX - 1; k++) begin : g_shift
      always_ff @(posedge clk) begin
         if (pix_vld)
            hist[k] <= hist[k+1];
      end
   end
endmodule

// File: rtl/sobel_grad_stage1.sv
`timescale 1ns/1ps
module sobel_grad_stage1
   import sobel_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int GRAD_W = PIX_W + 3
) (
   input  logic                           clk,
   input  logic [HIST_PIX-1:0][PIX_W-1:0] hist,
   input  logic [PIX_W-1:0]               p8,
   input  logic                           fire8,
   output logic signed [GRAD_W-1:0]       part_gx,
   output logic signed [GRAD_W-1:0]       part_gy
);
   localparam int PAD_W = GRAD_W - PIX_W;

   logic signed [GRAD_W-1:0] ext [8];

   for (genvar k = 0; k < 8; k++) begin : g_ext
      if (k < HIST_PIX) begin : g_hist
         assign ext[k] = $signed({{PAD_W{1'b0}}, hist[k]});
      end else begin : g_live
         assign ext[k] = $signed({{PAD_W{1'b0}}, p8});
      end
   end

   logic signed [GRAD_W-1:0] gx_c, gy_c;

   // partial sums without the bottom-right pixel; weights of two as shifts
   always_comb begin
      gx_c = (ext[2] - ext[0]) + ((ext[5] - ext[3]) <<< 1) - ext[6];
      gy_c = (ext[6] - ext[0]) + ((ext[7] - ext[1]) <<< 1) - ext[2];
   end

   always_ff @(posedge clk) begin
      if (fire8) begin
         part_gx <= gx_c;
         part_gy <= gy_c;
      end
   end
endmodule

// File: rtl/sobel_mag_thresh.sv
`timescale 1ns/1ps
module sobel_mag_thresh #(
   parameter int PIX_W  = 8,
   parameter int GRAD_W = PIX_W + 3,
   parameter int MAG_W  = PIX_W + 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [GRAD_W-1:0] part_gx,
   input  logic signed [GRAD_W-1:0] part_gy,
   input  logic [PIX_W-1:0]         p9,
   input  logic [MAG_W-1:0]         thr,
   input  logic                     fire9,
   output logic                     edge_vld,
   output logic [PIX_W-1:0]         edge_pix
);
   localparam int PAD_W = GRAD_W - PIX_W;

   logic signed [GRAD_W-1:0] p9_s, gx, gy;
   logic [GRAD_W-1:0]        ax, ay;
   logic [MAG_W-1:0]         mag;
   logic                     hit;

   always_comb begin
      p9_s = $signed({{PAD_W{1'b0}}, p9});
      gx   = part_gx + p9_s;
      gy   = part_gy + p9_s;
      ax   = gx[GRAD_W-1] ? GRAD_W'(-gx) : GRAD_W'(gx);
      ay   = gy[GRAD_W-1] ? GRAD_W'(-gy) : GRAD_W'(gy);
      mag  = MAG_W'(ax) + MAG_W'(ay);
      hit  = mag > thr;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         edge_vld <= 1'b0;
         edge_pix <= '0;
      end else begin
         edge_vld <= fire9;
         if (fire9)
            edge_pix <= hit ? '1 : '0;
      end
   end
endmodule

// File: rtl/sobel_edge_core.sv
`timescale 1ns/1ps
module sobel_edge_core
   import sobel_pkg::*;
#(
   parameter int PIX_W  = 8,
   localparam int GRAD_W = PIX_W + 3,
   localparam int MAG_W  = PIX_W + 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pix_vld,
   input  logic [PIX_W-1:0] pix,
   input  logic [MAG_W-1:0] thr,
   output logic             edge_vld,
   output logic [PIX_W-1:0] edge_pix
);
   if (PIX_W < 2 || PIX_W > 16) begin : g_bad_width
      $error("sobel_edge_core: PIX_W must lie in 2..16");
   end

   logic [HIST_PIX-1:0][PIX_W-1:0] hist;
   logic                           fire8, fire9;
   logic signed [GRAD_W-1:0]       part_gx, part_gy;

   sobel_win_loader #(.PIX_W(PIX_W)) u_load (
      .clk     (clk),
      .rst     (rst),
      .pix_vld (pix_vld),
      .pix     (pix),
      .hist    (hist),
      .fire8   (fire8),
      .fire9   (fire9)
   );

   sobel_grad_stage1 #(.PIX_W(PIX_W), .GRAD_W(GRAD_W)) u_st1 (
      .clk     (clk),
      .hist    (hist),
      .p8      (pix),
      .fire8   (fire8),
      .part_gx (part_gx),
      .part_gy (part_gy)
   );

   sobel_mag_thresh #(.PIX_W(PIX_W), .GRAD_W(GRAD_W), .MAG_W(MAG_W)) u_st2 (
      .clk      (clk),
      .rst      (rst),
      .part_gx  (part_gx),
      .part_gy  (part_gy),
      .p9       (pix),
      .thr      (thr),
      .fire9    (fire9),
      .edge_vld (edge_vld),
      .edge_pix (edge_pix)
   );
endmodule

// File: rtl/sobel_edge_core_chk.sv
`timescale 1ns/1ps
module sobel_edge_core_chk #(
   parameter int PIX_W = 8,
   parameter int MAG_W = PIX_W + 4
) (
   input logic             clk,
   input logic             rst,
   input logic             pix_vld,
   input logic [PIX_W-1:0] pix,
   input logic [MAG_W-1:0] thr,
   input logic             edge_vld,
   input logic [PIX_W-1:0] edge_pix
);
   logic [3:0] seen;

   always_ff @(posedge clk) begin
      if (rst)
         seen <= '0;
      else if (pix_vld)
         seen <= (seen == 4'd8) ? 4'd0 : seen + 4'd1;
   end

   p_reset_clear_r1: assert property (@(posedge clk) rst |=> !edge_vld);

   p_binary_out_r4: assert property (@(posedge clk) disable iff (rst)
      edge_vld |-> (edge_pix == '1 || edge_pix == '0));

   p_single_strobe_r5: assert property (@(posedge clk) disable iff (rst)
      edge_vld |=> !edge_vld);

   p_after_ninth_r6: assert property (@(posedge clk) disable iff (rst)
      edge_vld |-> ($past(pix_vld) && $past(seen) == 4'd8));

   p_hold_out_r8: assert property (@(posedge clk) disable iff (rst)
      !edge_vld |-> $stable(edge_pix));
endmodule

bind sobel_edge_core sobel_edge_core_chk #(.PIX_W(PIX_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pix_vld  (pix_vld),
   .pix      (pix),
   .thr      (thr),
   .edge_vld (edge_vld),
   .edge_pix (edge_pix)
);

// File: tb/test_sobel_edge_core.sv
`timescale 1ns/1ps
module test_sobel_edge_core;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pix_vld = 1'b0;
   logic [7:0]  pix = '0;
   logic [11:0] thr = '0;
   logic        edge_vld;
   logic [7:0]  edge_pix;

   always #2 clk = ~clk;

   sobel_edge_core i_sobel_edge_core (
      .clk(clk), .rst(rst), .pix_vld(pix_vld), .pix(pix),
      .thr(thr), .edge_vld(edge_vld), .edge_pix(edge_pix)
   );

   int    n_run = 0, n_bad = 0;
   int    win [9];
   int    wcnt = 0;
   bit    due = 0;
   int    exp_pix = 0;
   int    last_pix = 0;
   string win_req = "R4";

   function automatic int mag_of(input int p[9]);
      int gx, gy;
      gx = (p[2] + 2*p[5] + p[8]) - (p[0] + 2*p[3] + p[6]);
      gy = (p[6] + 2*p[7] + p[8]) - (p[0] + 2*p[1] + p[2]);
      return (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_run++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // look at outputs in the current cycle, before driving the next one
   task automatic observe();
      if (due) begin
         check(edge_vld === 1'b1, "R5", int'(edge_vld), 1);
         check(int'(edge_pix) == exp_pix, win_req, int'(edge_pix), exp_pix);
         last_pix = int'(edge_pix);
         due = 0;
      end else begin
         check(edge_vld === 1'b0, "R6", int'(edge_vld), 0);
         check(int'(edge_pix) == last_pix, "R8", int'(edge_pix), last_pix);
      end
   endtask

   task automatic step(input bit v, input int d, input int t);
      @(negedge clk);
      observe();
      pix_vld = v;
      pix     = 8'(d);
      thr     = 12'(t);
      if (v) begin
         win[wcnt] = d;
         wcnt++;
         if (wcnt == 9) begin
            exp_pix = (mag_of(win) > t) ? 255 : 0;
            due  = 1;
            wcnt = 0;
         end
      end
   endtask

   task automatic send(input int p[9], input int t, input bit gaps, input string req);
      win_req = req;
      for (int i = 0; i < 9; i++) begin
         step(1'b1, p[i], t);
         if (gaps && i < 8) step(1'b0, int'($urandom_range(255)), int'($urandom_range(4095)));
      end
   endtask

   // threshold one below and exactly at the model magnitude pins the value
   task automatic probe(input int p[9], input string req);
      int m;
      m = mag_of(p);
      if (m > 0) send(p, m - 1, 1'b0, req);
      send(p, m, 1'b0, req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      observe();
      rst = 1'b1; pix_vld = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(edge_vld === 1'b0, "R1", int'(edge_vld), 0);
      check(edge_pix == 8'h00, "R1", int'(edge_pix), 0);
      rst = 1'b0;
      wcnt = 0; due = 0; last_pix = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_run++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      int p[9];
      void'($urandom(32'd1234));
      do_reset();

      p = '{0,0,0,0,0,0,0,0,0};        send(p, 0, 1'b0, "R4");      // flat, equal -> black
      p = '{10,0,90,10,0,90,10,0,90};  probe(p, "R2");              // vertical edge, gx only
      p = '{200,0,0,200,0,0,200,0,0};  probe(p, "R2");              // negative gx
      p = '{5,5,5,0,0,0,77,77,77};     probe(p, "R3");              // horizontal edge, gy only
      p = '{99,99,99,0,0,0,0,0,0};     probe(p, "R3");              // negative gy
      p = '{0,0,0,0,9,255,0,255,255};  probe(p, "R10");             // magnitude 1530
      p = '{255,255,0,255,9,0,0,0,0};  probe(p, "R10");             // mirrored, 1530
      send(p, 4095, 1'b0, "R10");
      p = '{1,2,3,4,5,6,7,8,9};        send(p, 3, 1'b1, "R6");      // idle gaps inside window
      p = '{30,0,0,0,0,0,0,0,200};     send(p, 0, 1'b1, "R6");

      // threshold changes before the last pixel must not matter
      p = '{0,0,50,0,0,50,0,0,50};
      win_req = "R9";
      for (int i = 0; i < 8; i++) step(1'b1, p[i], 4095);
      step(1'b1, p[8], 0);
      win_req = "R9";
      for (int i = 0; i < 8; i++) step(1'b1, p[i], 0);
      step(1'b1, p[8], 4095);

      // reset in the middle of a window restarts the count
      for (int i = 0; i < 4; i++) step(1'b1, 250, 0);
      do_reset();
      p = '{0,0,0,0,0,0,0,0,0};        send(p, 0, 1'b0, "R1");
      p = '{0,0,0,0,0,0,0,0,1};        send(p, 1, 1'b0, "R1");
      send(p, 0, 1'b0, "R1");

      // back-to-back and gapped random windows
      for (int w = 0; w < 80; w++) begin
         for (int i = 0; i < 9; i++) p[i] = int'($urandom_range(255));
         if (w % 3 == 0) begin
            for (int i = 0; i < 9; i++) p[i] = (i % 3 == 2) ? 255 - (p[i] % 40) : p[i] % 40;
         end
         send(p, int'($urandom_range(1600)), (w % 4 == 3), "R7");
      end
      p = '{3,1,4,1,5,9,2,6,5};
      probe(p, "R7");

      step(1'b0, 0, 0);
      step(1'b0, 0, 0);
      step(1'b0, 0, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule